// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog. A 16-bit counter counts upward from a value that software loads, and it advances on ticks from a prescaler with eight divide ratios. To set a timeout of N ticks, software loads 65536 − N. When the counter steps past 0xFFFF while the timer is enabled, the block pulses a reset request for one cycle and sets a sticky overflow flag. Software reads this flag after the reset to find out what caused it.

The block guards every register write with a key in the upper bits of the write data, and each register has its own key. After a write is accepted, a busy flag blocks further writes for a few cycles. Software polls this flag before it sets the enable bit. The register file holds three words: a count word at offset 0x0, a control/status word at offset 0x4 and a spare control byte at offset 0x8. Reads are registered, and the upper bits of read data are always zero.

Top module: `keyed_watchdog`

## Requirements
- R1: After synchronous reset, the count, control/status and spare registers all read 0, and `rst_req` is 0.
- R2: A write to offset 0x0 loads wdata[15:0] into the counter only when wdata[31:16] is 0x5A5A. With any other upper value the write is ignored.
- R3: A write to offset 0x4 or 0x8 takes effect only when wdata[31:8] is 0xA5A5A5. With any other upper value, including the count key, the write is ignored.
- R4: After an accepted write, the busy flag (bit 5 of offset 0x4) reads 1 for 3 clock cycles. Writes that arrive while it is set are ignored. A rejected write does not start the busy window.
- R5: While the enable bit (bit 7 of offset 0x4) is 0, the counter holds its value.
- R6: Bits [2:0] of offset 0x4 select the divide ratio. Codes 0 to 7 give 1, 4, 16, 32, 64, 128, 1024 and 4096. After an enable at edge E and a disable at edge D, the counter has advanced by floor((D−E)/ratio).
- R7: When a tick arrives with the counter at 0xFFFF, the counter wraps to 0, the overflow flag (bit 4 of offset 0x4) sets, and `rst_req` is high for exactly the one following cycle.
- R8: The overflow flag clears only on a reset or an accepted write to offset 0x4 with bit 4 at 0. Writing 1 to bit 4, a rejected write, or the reset-request pulse leaves it set.
- R9: A read returns data one cycle after `re`, with bits [31:16] at zero. Offset 0x8 returns its last accepted byte. Unmapped offsets return 0.
- R10: The counter can be read while it is running, and the value returned is the count just before the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the prescaler input |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data, key in the upper bits |
| rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
Read data is due on the clock edge after `re`. The monitor therefore pops its expected value at the falling edge that follows the read edge. The bench times each counter expectation by counting edges. An enable accepted at edge E gives its first tick at edge E+ratio. A read captures the count as it stood before its own edge. For an enable at E with the counter preloaded to 0xFFFD, the reset request is due after edge E+3. The bench samples `rst_req` at the falling edges around that point, so both the pulse and its single-cycle width are checked. The busy window is checked with writes placed one and four cycles after an accepted write.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_AUX  = 4'h8;
  localparam logic [15:0] KEY_CNT  = 16'h5A5A;
  localparam logic [23:0] KEY_CTRL = 24'hA5A5A5;
  localparam int BIT_OVF  = 4;
  localparam int BIT_BUSY = 5;
  localparam int BIT_EN   = 7;

  // log2 of the divide ratio for each select code
  function automatic logic [3:0] div_shift(input logic [2:0] code);
    case (code)
      3'd0: div_shift = 4'd0;
      3'd1: div_shift = 4'd2;
      3'd2: div_shift = 4'd4;
      3'd3: div_shift = 4'd5;
      3'd4: div_shift = 4'd6;
      3'd5: div_shift = 4'd7;
      3'd6: div_shift = 4'd10;
      default: div_shift = 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/kwdt_key_gate.sv
module kwdt_key_gate
  import kwdt_pkg::*;
#(
  parameter int BUSY_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              cnt_wr,
  output logic              ctrl_wr,
  output logic              aux_wr,
  output logic              busy
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [BW-1:0] busy_cnt;
  logic          open_wr;
  logic          cnt_key_ok;
  logic          ctrl_key_ok;

  assign cnt_key_ok  = (wdata[31:16] == KEY_CNT);
  assign ctrl_key_ok = (wdata[31:8] == KEY_CTRL);
  assign open_wr     = we && !busy;

  assign cnt_wr  = open_wr && (addr == OFS_CNT)  && cnt_key_ok;
  assign ctrl_wr = open_wr && (addr == OFS_CTRL) && ctrl_key_ok;
  assign aux_wr  = open_wr && (addr == OFS_AUX)  && ctrl_key_ok;
  assign busy    = (busy_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
    end else if (cnt_wr || ctrl_wr || aux_wr) begin
      busy_cnt <= BW'(BUSY_CYCLES);
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
  import kwdt_pkg::*;
#(
  parameter int PS_W = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PS_W-1:0] pcnt;
  logic [PS_W:0]   one_sh;
  logic [PS_W-1:0] mask;

  always_comb begin
    one_sh = (PS_W+1)'(1) << div_shift(sel);
    mask   = one_sh[PS_W-1:0] - PS_W'(1);
  end

  assign tick = run && ((pcnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 12,
  parameter int BUSY_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req
);
  logic             cnt_wr, ctrl_wr, aux_wr, busy, tick, wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       cks_q;
  logic             ovf_q, en_q, rst_req_q;
  logic [7:0]       aux_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  kwdt_key_gate #(.BUSY_CYCLES(BUSY_CYCLES)) u_gate (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
    .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr), .aux_wr(aux_wr), .busy(busy)
  );

  kwdt_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst(rst), .run(en_q), .sel(cks_q), .tick(tick)
  );

  assign wrap = tick && (cnt_q == '1);

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CNT:  rd_mux[CNT_W-1:0] = cnt_q;
      OFS_CTRL: begin
        rd_mux[2:0]      = cks_q;
        rd_mux[BIT_OVF]  = ovf_q;
        rd_mux[BIT_BUSY] = busy;
        rd_mux[BIT_EN]   = en_q;
      end
      OFS_AUX:  rd_mux[7:0] = aux_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      cks_q     <= '0;
      ovf_q     <= 1'b0;
      en_q      <= 1'b0;
      aux_q     <= '0;
      rst_req_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (cnt_wr) begin
        cnt_q <= wdata[CNT_W-1:0];
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (ctrl_wr) begin
        cks_q <= wdata[2:0];
        en_q  <= wdata[BIT_EN];
      end
      if (wrap) begin
        ovf_q <= 1'b1;
      end else if (ctrl_wr && !wdata[BIT_OVF]) begin
        ovf_q <= 1'b0;
      end
      if (aux_wr) begin
        aux_q <= wdata[7:0];
      end
      rst_req_q <= wrap;
      if (re) begin
        rdata_q <= rd_mux;
      end
    end
  end

  assign rdata   = rdata_q;
  assign rst_req = rst_req_q;
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rst_req,
  input logic [31:0]      rdata,
  input logic [31:0]      wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_q,
  input logic             en_q,
  input logic             busy,
  input logic             cnt_wr,
  input logic             ctrl_wr
);
  a_r7_req_single: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  a_r7_req_sets_flag: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ovf_q);

  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (rst_req && !$past(cnt_wr)) |-> (cnt_q == '0));

  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !cnt_wr) |=> $stable(cnt_q));

  a_r4_busy_after_write: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr || ctrl_wr) |=> busy);

  a_r8_ovf_clear_cause: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(ovf_q)) |-> ($past(ctrl_wr) && !$past(wdata[4])));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[31:16] == 16'h0);
endmodule

bind keyed_watchdog kwdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rst_req(rst_req), .rdata(rdata), .wdata(wdata),
  .cnt_q(cnt_q), .ovf_q(ovf_q), .en_q(en_q), .busy(busy),
  .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr)
);

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;
  logic        re_d;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog dut_i (
    .clk(clk), .rst(rst), .we(we), .re(re), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  always_ff @(posedge clk) re_d <= rst ? 1'b0 : re;

  // monitor: compares each read result one edge after its strobe
  always @(negedge clk) begin
    if (re_d) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr_ok(input logic [3:0] a, input logic [31:0] d);
    wr(a, d);
    idle(3);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic chk_req(input logic e, input string t);
    total++;
    if (rst_req !== e) begin
      bad++;
      $display("FAIL %s: rst_req=%b expected=%b", t, rst_req, e);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R1 reset state
    rd(4'h0, 32'h0, "R1 count");
    rd(4'h4, 32'h0, "R1 ctrl");
    rd(4'h8, 32'h0, "R1 aux");
    chk_req(1'b0, "R1 rst_req");
    // R2 count key
    wr_ok(4'h0, 32'h5A5A_1234);
    rd(4'h0, 32'h0000_1234, "R2 keyed load");
    wr_ok(4'h0, 32'h5A5B_ABCD);
    rd(4'h0, 32'h0000_1234, "R2 wrong key ignored");
    // R3 control key
    wr_ok(4'h8, 32'hA5A5_A5C3);
    rd(4'h8, 32'h0000_00C3, "R3 R9 aux readback");
    wr_ok(4'h8, 32'hA5A5_A43C);
    rd(4'h8, 32'h0000_00C3, "R3 aux wrong key");
    wr_ok(4'h4, 32'h5A5A_0083);
    rd(4'h4, 32'h0, "R3 ctrl count-key ignored");
    rd(4'hC, 32'h0, "R9 unmapped");
    // R4 busy window
    wr(4'h0, 32'h5A5A_1111);
    wr(4'h0, 32'h5A5A_2222);
    rd(4'h4, 32'h0000_0020, "R4 busy flag");
    rd(4'h0, 32'h0000_1111, "R4 write during busy ignored");
    wr_ok(4'h0, 32'h5A5A_3333);
    rd(4'h0, 32'h0000_3333, "R4 write after window");
    // R6 ratio 1, then R5 hold
    wr_ok(4'h0, 32'h5A5A_0100);
    wr(4'h4, 32'hA5A5_A580);
    idle(9);
    wr_ok(4'h4, 32'hA5A5_A500);
    rd(4'h0, 32'h0000_010A, "R6 ratio 1");
    idle(10);
    rd(4'h0, 32'h0000_010A, "R5 hold while off");
    // R6 ratio 4
    wr_ok(4'h0, 32'h5A5A_0000);
    wr(4'h4, 32'hA5A5_A581);
    idle(15);
    wr_ok(4'h4, 32'hA5A5_A501);
    rd(4'h0, 32'h0000_0004, "R6 ratio 4");
    // R6 ratio 16
    wr_ok(4'h0, 32'h5A5A_0000);
    wr(4'h4, 32'hA5A5_A582);
    idle(47);
    wr_ok(4'h4, 32'hA5A5_A502);
    rd(4'h0, 32'h0000_0003, "R6 ratio 16");
    // R10 read while running
    wr_ok(4'h0, 32'h5A5A_0500);
    wr(4'h4, 32'hA5A5_A580);
    idle(3);
    rd(4'h0, 32'h0000_0503, "R10 running read 1");
    rd(4'h0, 32'h0000_0504, "R10 running read 2");
    wr_ok(4'h4, 32'hA5A5_A500);
    // R7 overflow
    wr_ok(4'h0, 32'h5A5A_FFFD);
    wr(4'h4, 32'hA5A5_A580);
    idle(2);
    chk_req(1'b0, "R7 no request before wrap");
    idle(1);
    chk_req(1'b1, "R7 request on wrap");
    idle(1);
    chk_req(1'b0, "R7 request one cycle");
    wr_ok(4'h4, 32'hA5A5_A510);
    rd(4'h4, 32'h0000_0010, "R7 overflow flag set");
    rd(4'h0, 32'h0000_0002, "R7 counter wrapped");
    // R8 sticky flag
    wr_ok(4'h4, 32'hA5A5_A510);
    rd(4'h4, 32'h0000_0010, "R8 write 1 keeps flag");
    wr_ok(4'h4, 32'h1234_5600);
    rd(4'h4, 32'h0000_0010, "R8 rejected write keeps flag");
    wr_ok(4'h4, 32'hA5A5_A500);
    rd(4'h4, 32'h0000_0000, "R8 write 0 clears flag");
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule